// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block sits on the host side of a four-wire resistive touch panel converter. While the panel is untouched it waits on an active-low pen-detect line. When contact is seen it runs one scan. The scan first requests a conversion that measures the vertical position, then a conversion that measures the horizontal position. Both coordinates are then reported together, and the block goes back to waiting for the pen.

Each request is an 8-bit command byte. It goes to a separate serial transfer engine over a valid/ready handshake, and the engine returns each result on a one-cycle response strobe. Two configuration inputs set the scan. One chooses 8-bit or 12-bit conversions. The other chooses a ratiometric (differential) reference or a single-ended reference. Both are captured when a scan begins. Every command asks the converter to power down after it finishes, so that pen detection is live again when the scan ends.

Top module: `tss_scan_seq`

## Requirements
- R1: After reset, `req_valid` and `coord_valid` are low, and both coordinate outputs are zero.
- R2: In the idle state, a low level on `pen_n` that has passed through the input synchronizer starts a scan, and `req_valid` then rises.
- R3: Every command byte has bit 7 set. The first command of a scan carries channel code 001 in bits 6:4 (vertical position). The second carries 101 (horizontal position).
- R4: Command bit 3 is 1 for an 8-bit conversion (`cfg_low_res` high) and 0 for a 12-bit conversion.
- R5: Command bit 2 is 0 for the ratiometric reference (`cfg_ratiometric` high) and 1 for the single-ended reference.
- R6: Command bits 1:0 are always 00 (power down after the conversion, pen detect enabled). The reserved codes 01 and 10 and the always-on code 11 never appear.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_byte` does not change.
- R8: The auxiliary channel codes 010 and 110 are never issued.
- R9: After the second response, `coord_valid` pulses for exactly one cycle. `coord_y` holds the first result and `coord_x` holds the second, and both keep their values until the next report.
- R10: In 8-bit mode, the response in `rsp_data[7:0]` is reported as `{rsp_data[7:0], 4'b0000}`. In 12-bit mode, `rsp_data` is reported unchanged.
- R11: `pen_n` is ignored from the start of a scan until the block is idle again. A pen held low through the scan starts a new scan only after the report.
- R12: Configuration changes made during a scan do not affect the commands or the result widening of that scan.
- R13: A `rsp_valid` pulse that arrives while no response is awaited changes neither the coordinates nor `coord_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pen_n | input | 1 | Asynchronous active-low pen contact line |
| cfg_low_res | input | 1 | 1 selects 8-bit conversions, 0 selects 12-bit |
| cfg_ratiometric | input | 1 | 1 selects ratiometric reference, 0 selects single-ended |
| req_valid | output | 1 | Command byte offered to the transfer engine |
| req_ready | input | 1 | Transfer engine accepts the command |
| req_byte | output | 8 | Command byte |
| rsp_valid | input | 1 | Conversion result present for one cycle |
| rsp_data | input | 12 | Conversion result (low 8 bits in 8-bit mode) |
| coord_valid | output | 1 | One-cycle strobe for a new coordinate pair |
| coord_x | output | 12 | Horizontal coordinate |
| coord_y | output | 12 | Vertical coordinate |

## Verification
The hardest condition to produce is a pen line that changes during a scan while stray strobes arrive on the response input. The bench holds the pen low through the vertical request and toggles it several times. It releases the pen well before the horizontal result and then checks that no further request appears after the report. In a separate scenario it fires a response strobe while a command is still stalled by a low `req_ready`, and checks that the reported pair comes only from the awaited results.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_Y,
        ST_WAIT_Y,
        ST_SEND_X,
        ST_WAIT_X,
        ST_REPORT
    } scan_state_e;

    typedef struct packed {
        logic low_res;
        logic ratiometric;
    } scan_cfg_t;

    localparam logic       CMD_START   = 1'b1;
    localparam logic [2:0] CH_MEAS_Y   = 3'b001;
    localparam logic [2:0] CH_MEAS_X   = 3'b101;
    localparam logic [1:0] PWR_AUTO_DN = 2'b00;

    function automatic logic [7:0] make_cmd(input logic [2:0] chan, input scan_cfg_t cfg);
        return {CMD_START, chan, cfg.low_res, ~cfg.ratiometric, PWR_AUTO_DN};
    endfunction

endpackage

// File: rtl/tss_pen_sync.sv
module tss_pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pen_n,
    output logic pen_active
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= pen_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign pen_active = ~chain[STAGES-1];
endmodule

// File: rtl/tss_cmd_build.sv
module tss_cmd_build
    import tss_pkg::*;
(
    input  logic      second_leg,
    input  scan_cfg_t cfg,
    output logic [7:0] cmd
);
    logic [2:0] chan;

    always_comb begin
        chan = second_leg ? CH_MEAS_X : CH_MEAS_Y;
        cmd  = make_cmd(chan, cfg);
    end
endmodule

// File: rtl/tss_coord_store.sv
module tss_coord_store #(
    parameter int RES_W = 12,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             low_res,
    input  logic             cap_y,
    input  logic             cap_x,
    input  logic [RES_W-1:0] rsp_data,
    output logic [RES_W-1:0] coord_x,
    output logic [RES_W-1:0] coord_y
);
    localparam int PAD_W = RES_W - LOW_W;

    logic [RES_W-1:0] widened;
    logic [RES_W-1:0] y_pend;

    always_comb begin
        if (low_res) widened = {rsp_data[LOW_W-1:0], {PAD_W{1'b0}}};
        else         widened = rsp_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_pend  <= '0;
            coord_x <= '0;
            coord_y <= '0;
        end else begin
            if (cap_y) y_pend <= widened;
            if (cap_x) begin
                coord_x <= widened;
                coord_y <= y_pend;
            end
        end
    end
endmodule

// File: rtl/tss_scan_seq.sv
module tss_scan_seq
    import tss_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int LOW_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pen_n,
    input  logic             cfg_low_res,
    input  logic             cfg_ratiometric,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [7:0]       req_byte,
    input  logic             rsp_valid,
    input  logic [RES_W-1:0] rsp_data,
    output logic             coord_valid,
    output logic [RES_W-1:0] coord_x,
    output logic [RES_W-1:0] coord_y
);
    scan_state_e state;
    scan_cfg_t   cfg_q;
    scan_cfg_t   cfg_in;
    logic        pen_active;
    logic        cap_y;
    logic        cap_x;
    logic        second_leg;

    assign cfg_in = '{low_res: cfg_low_res, ratiometric: cfg_ratiometric};

    tss_pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pen_n      (pen_n),
        .pen_active (pen_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (pen_active) begin
                    cfg_q <= cfg_in;
                    state <= ST_SEND_Y;
                end
                ST_SEND_Y: if (req_ready) state <= ST_WAIT_Y;
                ST_WAIT_Y: if (rsp_valid) state <= ST_SEND_X;
                ST_SEND_X: if (req_ready) state <= ST_WAIT_X;
                ST_WAIT_X: if (rsp_valid) state <= ST_REPORT;
                ST_REPORT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign req_valid   = (state == ST_SEND_Y) || (state == ST_SEND_X);
    assign second_leg  = (state == ST_SEND_X);
    assign coord_valid = (state == ST_REPORT);
    assign cap_y       = (state == ST_WAIT_Y) && rsp_valid;
    assign cap_x       = (state == ST_WAIT_X) && rsp_valid;

    tss_cmd_build u_cmd (
        .second_leg (second_leg),
        .cfg        (cfg_q),
        .cmd        (req_byte)
    );

    tss_coord_store #(.RES_W(RES_W), .LOW_W(LOW_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .low_res  (cfg_q.low_res),
        .cap_y    (cap_y),
        .cap_x    (cap_x),
        .rsp_data (rsp_data),
        .coord_x  (coord_x),
        .coord_y  (coord_y)
    );
endmodule

// File: rtl/tss_scan_seq_chk.sv
module tss_scan_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [7:0] req_byte,
    input logic       coord_valid
);
    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_byte[7]);

    // R3
    scan_chan_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_byte[6:4] == 3'b001 || req_byte[6:4] == 3'b101));

    // R8
    no_aux_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_byte[5:4] != 2'b10));

    // R6
    pwr_code_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_byte[1:0] == 2'b00));

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_byte)));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        coord_valid |=> !coord_valid);

    // R11
    idle_after_report_chk: assert property (@(posedge clk) disable iff (rst)
        coord_valid |=> !req_valid);
endmodule

bind tss_scan_seq tss_scan_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_byte    (req_byte),
    .coord_valid (coord_valid)
);

// File: tb/tss_scan_seq_bench.sv
module tss_scan_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pen_n = 1'b1;
    logic        cfg_low_res = 1'b0;
    logic        cfg_ratiometric = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [7:0]  req_byte;
    logic        rsp_valid = 1'b0;
    logic [11:0] rsp_data = '0;
    logic        coord_valid;
    logic [11:0] coord_x;
    logic [11:0] coord_y;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tss_scan_seq u_tss_scan_seq (
        .clk             (clk),
        .rst             (rst),
        .pen_n           (pen_n),
        .cfg_low_res     (cfg_low_res),
        .cfg_ratiometric (cfg_ratiometric),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_byte        (req_byte),
        .rsp_valid       (rsp_valid),
        .rsp_data        (rsp_data),
        .coord_valid     (coord_valid),
        .coord_x         (coord_x),
        .coord_y         (coord_y)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_req(input string req);
        int n;
        n = 0;
        while (!req_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(req_valid, req, "request did not appear", int'(req_valid), 1);
    endtask

    // Offer a command, stall it, accept it, then return a result.
    task automatic serve(input logic [7:0] exp, input string req, input int stall,
                         input logic [11:0] res, input int gap);
        wait_req(req);
        check(req_byte == exp, req, "command byte", req_byte, exp);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(req_valid && req_byte == exp, "R7", "held command", req_byte, exp);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check(!req_valid, req, "valid after accept", int'(req_valid), 0);
        repeat (gap) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = res;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_data  = 12'hFFF;
    endtask

    task automatic check_report(input logic [11:0] ex, input logic [11:0] ey, input string req);
        check(coord_valid, "R9", "report strobe", int'(coord_valid), 1);
        check(coord_x == ex, req, "coord_x", coord_x, ex);
        check(coord_y == ey, req, "coord_y", coord_y, ey);
        @(negedge clk);
        check(!coord_valid, "R9", "strobe width", int'(coord_valid), 0);
        check(coord_x == ex && coord_y == ey, "R9", "coords held", coord_x, ex);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (req_valid || coord_valid) seen = 1'b1;
        end
        check(!seen, req, "unexpected activity", int'(seen), 0);
    endtask

    task automatic t_reset;
        check(!req_valid && !coord_valid, "R1", "reset outputs", {req_valid, coord_valid}, 0);
        check(coord_x == 0 && coord_y == 0, "R1", "reset coords", coord_x, 0);
        expect_quiet(10, "R2");
    endtask

    // R3 R4 R5 R6 R10: 12-bit single-ended scan
    task automatic t_scan_12_single;
        cfg_low_res = 1'b0; cfg_ratiometric = 1'b0;
        pen_n = 1'b0;
        wait_req("R2");
        pen_n = 1'b1;
        serve(8'h94, "R5", 0, 12'h3A7, 2);
        serve(8'hD4, "R3", 0, 12'hC12, 3);
        check_report(12'hC12, 12'h3A7, "R10");
        expect_quiet(12, "R11");
    endtask

    // R4 R5 R10: 8-bit ratiometric scan with stalls
    task automatic t_scan_8_ratio;
        cfg_low_res = 1'b1; cfg_ratiometric = 1'b1;
        pen_n = 1'b0;
        wait_req("R2");
        pen_n = 1'b1;
        serve(8'h98, "R4", 3, 12'hFA5, 1);
        serve(8'hD8, "R6", 2, 12'h03C, 0);
        check_report(12'h3C0, 12'hA50, "R10");
        expect_quiet(8, "R11");
    endtask

    // R11: pen toggles during scan, then a held pen rescans only after report
    task automatic t_pen_during_scan;
        cfg_low_res = 1'b0; cfg_ratiometric = 1'b1;
        pen_n = 1'b0;
        wait_req("R2");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pen_n = ~pen_n;
        end
        check(req_byte == 8'h90, "R11", "command during toggles", req_byte, 8'h90);
        pen_n = 1'b1;
        serve(8'h90, "R11", 1, 12'h111, 4);
        serve(8'hD0, "R11", 0, 12'h222, 4);
        check_report(12'h222, 12'h111, "R11");
        expect_quiet(20, "R11");
        pen_n = 1'b0;
        serve(8'h90, "R11", 0, 12'h333, 1);
        check(!coord_valid, "R11", "no report mid scan", int'(coord_valid), 0);
        serve(8'hD0, "R11", 0, 12'h444, 1);
        check_report(12'h444, 12'h333, "R11");
        @(negedge clk);
        check(req_valid, "R11", "held pen rescans", int'(req_valid), 1);
        pen_n = 1'b1;
        serve(8'h90, "R11", 0, 12'h555, 1);
        serve(8'hD0, "R11", 0, 12'h666, 1);
        check_report(12'h666, 12'h555, "R11");
        expect_quiet(10, "R11");
    endtask

    // R12: configuration flips mid scan
    task automatic t_cfg_mid_scan;
        cfg_low_res = 1'b1; cfg_ratiometric = 1'b0;
        pen_n = 1'b0;
        wait_req("R2");
        pen_n = 1'b1;
        cfg_low_res = 1'b0; cfg_ratiometric = 1'b1;
        serve(8'h9C, "R12", 0, 12'h0AB, 1);
        serve(8'hDC, "R12", 0, 12'h0CD, 1);
        check_report(12'hCD0, 12'hAB0, "R12");
        expect_quiet(8, "R12");
    endtask

    // R13: stray responses while idle and while a command is stalled
    task automatic t_stray_rsp;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 12'h777;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(!coord_valid, "R13", "idle stray strobe", int'(coord_valid), 0);
        check(coord_x == 12'hCD0 && coord_y == 12'hAB0, "R13", "idle stray coords", coord_x, 12'hCD0);
        cfg_low_res = 1'b0; cfg_ratiometric = 1'b0;
        pen_n = 1'b0;
        wait_req("R2");
        pen_n = 1'b1;
        rsp_valid = 1'b1; rsp_data = 12'hBAD;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(req_valid, "R13", "stray during offer", int'(req_valid), 1);
        serve(8'h94, "R13", 1, 12'h5A5, 2);
        serve(8'hD4, "R13", 0, 12'h6B6, 2);
        check_report(12'h6B6, 12'h5A5, "R13");
        expect_quiet(5, "R13");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_scan_12_single();
        t_scan_8_ratio();
        t_pen_during_scan();
        t_cfg_mid_scan();
        t_stray_rsp();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule